// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that is reached through a simple 32-bit register bus. A 16-bit counter counts upward at a rate that a prescaler sets. When the counter passes its top value it rolls over to zero. At that point the block latches a sticky expiry flag and drives a single-cycle pulse that the chip's reset logic can consume. To set a timeout of N ticks, software loads the counter with 65536 minus N. Software then has to reload the counter before the count expires.

Each register write carries a guard pattern in its upper bits, and the pattern is different for each register. A write whose pattern does not match changes nothing, so a stray store cannot stop or feed the watchdog. A counter reload does not take effect at once. The value is held as pending for a fixed number of cycles, and during that time a busy bit reads as set and the counter is frozen. The value is then copied into the counter. The control register enables counting, selects the prescale ratio, reports the busy bit and holds the expiry flag.

Top module: `keyed_wdt`

## Requirements
- R1: After a synchronous reset, both registers read zero and `wdt_expire` is low.
- R2: A write to offset 0 is accepted only when bits 31:16 equal 0x5A5A. Its bits 15:0 become the counter value 3 cycles after the write edge.
- R3: After an accepted counter write, bit 5 of the control register reads 1 for exactly 3 cycles and then reads 0. The counter does not change while this bit is 1.
- R4: A write to offset 4 is accepted only when bits 31:24 and 23:8 together equal 0xA5A5A5. Bit 7 sets the enable and bits 2:0 set the prescale code.
- R5: A write with a wrong guard pattern, or a write to any other offset, leaves every register unchanged.
- R6: While the enable is 0, the counter holds its value.
- R7: Prescale codes 0 to 6 give one counter increment every 1, 4, 16, 32, 64, 128 and 1024 enabled cycles, and code 7 gives 1024. The first increment comes that many cycles after the enabling edge.
- R8: An accepted control write that changes the prescale code restarts the prescale count from zero.
- R9: When an increment takes the counter from 0xFFFF to 0, bit 4 of the control register becomes 1 and `wdt_expire` is high for exactly one cycle.
- R10: Bit 4 stays at 1 until an accepted control write has bit 4 equal to 0. Writing 1 to bit 4 does not clear it.
- R11: Offset 0 reads {16'h0, counter}. Offset 4 reads {24'h0, enable, 0, busy, expiry, 0, code}. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data, including the guard pattern |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_expire | output | 1 | One-cycle expiry pulse |

## Verification
The hardest case to reach from the ports is a rollover under the slowest prescale. It needs the counter preloaded close to 0xFFFF, the 3-cycle reload window allowed to finish, and then more than a thousand enabled cycles with no stray write in between. A directed sequence preloads 0xFFFF with code 7 and checks the pulse on the exact 1024th cycle. Random traffic often loads values just below 0xFFFF at fast ratios, so that rollovers fall close to reloads, code changes and flag-clearing writes. A cycle-level bench model checks every cycle of that traffic.

// File: rtl/wdt_pkg.sv
// Package: shared constants and helpers for the keyed watchdog.
// Assumes a 32-bit data bus and byte offsets for the register addresses.
package wdt_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 16;
    localparam int CKS_W    = 3;
    localparam int PS_W     = 10;                 // wide enough for a limit of 1023
    localparam logic [15:0] CNT_GUARD = 16'h5A5A;
    localparam logic [23:0] CTL_GUARD = 24'hA5A5A5;
    localparam int EN_BIT   = 7;
    localparam int BUSY_BIT = 5;
    localparam int EXP_BIT  = 4;

    // Prescale limit (ratio minus one) for a code; code 7 uses the largest ratio.
    function automatic logic [PS_W-1:0] ps_limit(input logic [CKS_W-1:0] code);
        logic [PS_W-1:0] lim;
        case (code)
            3'd0:    lim = PS_W'(0);
            3'd1:    lim = PS_W'(3);
            3'd2:    lim = PS_W'(15);
            3'd3:    lim = PS_W'(31);
            3'd4:    lim = PS_W'(63);
            3'd5:    lim = PS_W'(127);
            default: lim = PS_W'(1023);
        endcase
        return lim;
    endfunction
endpackage

// File: rtl/wdt_prescaler.sv
// Module: wdt_prescaler
// Produces a one-cycle tick every (limit+1) enabled cycles for the selected
// code. Assumes clr_i pulses for one cycle when the code changes. While the
// timer is disabled the count is held at zero.
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CKS_W-1:0] cks_i,
    input  logic             clr_i,
    output logic             tick_o
);
    logic [PS_W-1:0] pc_q;
    logic [PS_W-1:0] lim;

    // Limit lookup for the current code.
    always_comb lim = ps_limit(cks_i);

    // A tick fires on the last count of an enabled period.
    always_comb tick_o = en_i && (pc_q == lim);

    // Count state: a code change or disable restarts it; it wraps at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pc_q <= '0;
        else if (clr_i || !en_i)         pc_q <= '0;
        else if (pc_q == lim)            pc_q <= '0;
        else                             pc_q <= pc_q + 1'b1;
    end

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && lim != '0 && !clr_i) |=> !tick_o);
endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Holds the 16-bit up-counter, the pending reload and its delay window.
// While a reload is pending the counter is frozen. A new reload restarts the
// window. A rollover from all ones raises wrap_now_o in the same cycle and a
// registered pulse one edge later.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int LOAD_DELAY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_req_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             busy_o,
    output logic             wrap_now_o,
    output logic             expire_o
);
    localparam int BC_W = $clog2(LOAD_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pend_q;
    logic [BC_W-1:0]  bc_q;
    logic             expire_q;

    // Rollover happens only on a tick with no reload in flight.
    always_comb wrap_now_o = !ld_req_i && (bc_q == '0) && tick_i && (cnt_q == CNT_MAX);

    // Pending value and window countdown for reloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            bc_q   <= '0;
        end else if (ld_req_i) begin
            pend_q <= ld_val_i;
            bc_q   <= BC_W'(LOAD_DELAY);
        end else if (bc_q != '0) begin
            bc_q   <= bc_q - 1'b1;
        end
    end

    // Counter: the reload lands at the end of the window, ticks advance otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt_q <= '0;
        else if (!ld_req_i && bc_q == BC_W'(1))      cnt_q <= pend_q;
        else if (!ld_req_i && bc_q == '0 && tick_i)  cnt_q <= cnt_q + 1'b1;
    end

    // One-cycle expiry pulse registered from the rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) expire_q <= 1'b0;
        else        expire_q <= wrap_now_o;
    end

    assign cnt_o    = cnt_q;
    assign busy_o   = (bc_q != '0);
    assign expire_o = expire_q;

    // R3
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_q > BC_W'(1) && !ld_req_i) |=> $stable(cnt_q));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_req_i && bc_q == '0 && !tick_i) |=> $stable(cnt_q));
    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |=> !expire_q);
    // R9
    pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |-> (cnt_q == '0));
endmodule

// File: rtl/wdt_regif.sv
// Module: wdt_regif
// Decodes guarded writes, holds the control fields and the expiry flag, and
// drives the read mux. Assumes one bus access per cycle and combinational
// reads. Guard bits always read back as zero.
module wdt_regif
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CNT_ADDR = 0,
    parameter int CTL_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              busy_i,
    input  logic              wrap_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              en_o,
    output logic [CKS_W-1:0]  cks_o,
    output logic              cks_chg_o,
    output logic              ld_req_o,
    output logic [CNT_W-1:0]  ld_val_o
);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CNT_ADDR);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);

    logic             en_q;
    logic [CKS_W-1:0] cks_q;
    logic             exp_q;
    logic             ctl_wr;
    logic             unused_wbits;

    // Guarded write decode for both registers.
    always_comb begin
        ld_req_o = we_i && (addr_i == A_CNT) && (wdata_i[31:16] == CNT_GUARD);
        ctl_wr   = we_i && (addr_i == A_CTL) && (wdata_i[31:8]  == CTL_GUARD);
    end

    assign ld_val_o     = wdata_i[CNT_W-1:0];
    assign cks_chg_o    = ctl_wr && (wdata_i[CKS_W-1:0] != cks_q);
    assign unused_wbits = ^{wdata_i[6:5], wdata_i[3]};

    // Control fields are written only by an accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cks_q <= '0;
        end else if (ctl_wr) begin
            en_q  <= wdata_i[EN_BIT];
            cks_q <= wdata_i[CKS_W-1:0];
        end
    end

    // Expiry flag: set by rollover (takes priority), cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                          exp_q <= 1'b0;
        else if (wrap_i)                     exp_q <= 1'b1;
        else if (ctl_wr && !wdata_i[EXP_BIT]) exp_q <= 1'b0;
    end

    // Read mux with guard bits and reserved bits returned as zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CNT) begin
            rdata_o[CNT_W-1:0] = cnt_i;
        end else if (addr_i == A_CTL) begin
            rdata_o[EN_BIT]      = en_q;
            rdata_o[BUSY_BIT]    = busy_i;
            rdata_o[EXP_BIT]     = exp_q;
            rdata_o[CKS_W-1:0]   = cks_q;
        end
    end

    assign en_o  = en_q;
    assign cks_o = cks_q;

    // R5
    bad_guard_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_CTL && wdata_i[31:8] != CTL_GUARD) |=> ($stable(en_q) && $stable(cks_q)));
    // R10
    exp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_q && !(ctl_wr && !wdata_i[EXP_BIT])) |=> exp_q);
    // R9
    exp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> exp_q);
endmodule

// File: rtl/keyed_wdt.sv
// Module: keyed_wdt (top)
// Guarded-write watchdog: register interface, prescaler and 16-bit counter.
// Assumes a single clock and synchronous active-low reset. The expiry output
// is a one-cycle pulse for external reset logic.
module keyed_wdt #(
    parameter int ADDR_W     = 4,
    parameter int CNT_ADDR   = 0,
    parameter int CTL_ADDR   = 4,
    parameter int LOAD_DELAY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              wdt_expire
);
    import wdt_pkg::*;

    logic             en;
    logic [CKS_W-1:0] cks;
    logic             cks_chg;
    logic             ld_req;
    logic [CNT_W-1:0] ld_val;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic             wrap_now;

    wdt_regif #(.ADDR_W(ADDR_W), .CNT_ADDR(CNT_ADDR), .CTL_ADDR(CTL_ADDR)) u_regif (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .we_i(bus_we), .cnt_i(cnt), .busy_i(busy), .wrap_i(wrap_now),
        .rdata_o(bus_rdata), .en_o(en), .cks_o(cks), .cks_chg_o(cks_chg),
        .ld_req_o(ld_req), .ld_val_o(ld_val)
    );

    wdt_prescaler u_ps (
        .clk(clk), .rst_n(rst_n), .en_i(en), .cks_i(cks), .clr_i(cks_chg),
        .tick_o(tick)
    );

    wdt_counter #(.LOAD_DELAY(LOAD_DELAY)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ld_req_i(ld_req), .ld_val_i(ld_val),
        .tick_i(tick), .cnt_o(cnt), .busy_o(busy), .wrap_now_o(wrap_now),
        .expire_o(wdt_expire)
    );
endmodule

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        wdt_expire;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    keyed_wdt u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .wdt_expire(wdt_expire)
    );

    // Reference model state
    logic [15:0] m_cnt, m_pend;
    int          m_bc, m_pc;
    bit          m_en, m_ovf, m_pulse;
    logic [2:0]  m_cks;

    function automatic int ratio(input logic [2:0] c);
        case (c)
            3'd0: return 1;    3'd1: return 4;   3'd2: return 16;
            3'd3: return 32;   3'd4: return 64;  3'd5: return 128;
            default: return 1024;
        endcase
    endfunction

    function automatic logic [31:0] ctl_word(input bit en, input bit ov, input logic [2:0] c);
        return {24'h0, en, 2'b00, ov, 1'b0, c};
    endfunction

    always @(posedge clk) begin
        bit cw, tw, tk, wr;
        if (!rst_n) begin
            m_cnt = 0; m_pend = 0; m_bc = 0; m_pc = 0;
            m_en = 0; m_ovf = 0; m_pulse = 0; m_cks = 0;
        end else begin
            cw = bus_we && bus_addr == 4'd0 && bus_wdata[31:16] == 16'h5A5A;
            tw = bus_we && bus_addr == 4'd4 && bus_wdata[31:8] == 24'hA5A5A5;
            tk = 0;
            if (!m_en) m_pc = 0;
            else if (m_pc == ratio(m_cks) - 1) begin tk = 1; m_pc = 0; end
            else m_pc++;
            if (tw && bus_wdata[2:0] != m_cks) m_pc = 0;
            wr = 0;
            if (cw) begin m_pend = bus_wdata[15:0]; m_bc = 3; end
            else if (m_bc != 0) begin if (m_bc == 1) m_cnt = m_pend; m_bc--; end
            else if (tk) begin if (m_cnt == 16'hFFFF) wr = 1; m_cnt++; end
            m_pulse = wr;
            if (wr) m_ovf = 1; else if (tw && !bus_wdata[4]) m_ovf = 0;
            if (tw) begin m_en = bus_wdata[7]; m_cks = bus_wdata[2:0]; end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    // Compare every visible value against the model (called at a falling edge).
    task automatic compare_all();
        logic [31:0] v;
        rd(4'd0, v);  chk("R2,R6,R7 counter", v, {16'h0, m_cnt});
        rd(4'd4, v);  chk("R3,R4,R10 control", v, ctl_word(m_en, m_ovf, m_cks) | (m_bc != 0 ? 32'h20 : 32'h0));
        rd(4'd8, v);  chk("R11 unmapped", v, 32'h0);
        chk("R9 pulse", {31'h0, wdt_expire}, {31'h0, m_pulse});
    endtask

    // Drive one cycle of stimulus, then compare after the edge.
    task automatic cyc(input bit we, input logic [3:0] a, input logic [31:0] d);
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 32'h0);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        rd(4'd0, v); chk("R1 counter", v, 32'h0);
        rd(4'd4, v); chk("R1 control", v, 32'h0);
        chk("R1 pulse", {31'h0, wdt_expire}, 32'h0);
        rst_n = 1'b1;

        // R2 and R3: guarded reload with 3-cycle busy window
        cyc(1, 4'd0, 32'h5A5A_1234);
        for (int i = 0; i < 2; i++) begin
            rd(4'd4, v); chk("R3 busy set", {31'h0, v[5]}, 32'h1);
            rd(4'd0, v); chk("R3 frozen", v, 32'h0);
            idle(1);
        end
        rd(4'd4, v); chk("R3 busy set", {31'h0, v[5]}, 32'h1);
        idle(1);
        rd(4'd4, v); chk("R3 busy clear", {31'h0, v[5]}, 32'h0);
        rd(4'd0, v); chk("R2 loaded", v, 32'h1234);

        // R5: wrong guards and wrong offset are ignored
        cyc(1, 4'd0, 32'h5A5B_0000); idle(3);
        rd(4'd0, v); chk("R5 bad counter guard", v, 32'h1234);
        cyc(1, 4'd4, 32'hA5A5A4_81);
        rd(4'd4, v); chk("R5 bad control guard", v, 32'h0);
        cyc(1, 4'd8, 32'hA5A5A5_81); idle(3);
        rd(4'd4, v); chk("R5 wrong offset", v, 32'h0);
        rd(4'd0, v); chk("R6 held while disabled", v, 32'h1234);

        // R4, R7: enable with ratio 4
        cyc(1, 4'd4, 32'hA5A5A5_81);
        rd(4'd4, v); chk("R4 control fields", v, 32'h81);
        idle(3);
        rd(4'd0, v); chk("R7 before 4th cycle", v, 32'h1234);
        idle(1);
        rd(4'd0, v); chk("R7 after 4th cycle", v, 32'h1235);

        // R8: code change restarts the prescale count
        idle(2);
        cyc(1, 4'd4, 32'hA5A5A5_82);
        idle(15);
        rd(4'd0, v); chk("R8 before 16th cycle", v, 32'h1235);
        idle(1);
        rd(4'd0, v); chk("R8 after 16th cycle", v, 32'h1236);

        // R9, R10: rollover at ratio 1
        cyc(1, 4'd4, 32'hA5A5A5_00);
        cyc(1, 4'd0, 32'h5A5A_FFFE); idle(3);
        cyc(1, 4'd4, 32'hA5A5A5_80);
        idle(1);
        chk("R9 no pulse yet", {31'h0, wdt_expire}, 32'h0);
        idle(1);
        chk("R9 pulse", {31'h0, wdt_expire}, 32'h1);
        rd(4'd4, v); chk("R9 flag set", v, 32'h90);
        idle(1);
        chk("R9 pulse one cycle", {31'h0, wdt_expire}, 32'h0);
        cyc(1, 4'd4, 32'hA5A5A5_90);
        rd(4'd4, v); chk("R10 writing 1 keeps flag", v, 32'h90);
        cyc(1, 4'd4, 32'hA5A5A4_00);
        rd(4'd4, v); chk("R10 bad guard keeps flag", v, 32'h90);
        cyc(1, 4'd4, 32'hA5A5A5_80);
        rd(4'd4, v); chk("R10 flag cleared", v, 32'h80);

        // R7: code 7 behaves as ratio 1024
        cyc(1, 4'd4, 32'hA5A5A5_00);
        cyc(1, 4'd0, 32'h5A5A_FFFF); idle(3);
        cyc(1, 4'd4, 32'hA5A5A5_87);
        idle(1023);
        rd(4'd0, v); chk("R7 code 7 before", v, 32'hFFFF);
        idle(1);
        chk("R7 code 7 pulse", {31'h0, wdt_expire}, 32'h1);
        rd(4'd0, v); chk("R7 code 7 wrapped", v, 32'h0);

        // Random traffic checked against the model every cycle
        for (int i = 0; i < 6000; i++) begin
            int s;
            logic [3:0] a;
            logic [31:0] d;
            bit good;
            s = $urandom % 8;
            a = (s < 4) ? 4'd0 : (s < 7) ? 4'd4 : ((s == 7 && ($urandom % 2)) ? 4'd8 : 4'd12);
            good = ($urandom % 10) < 8;
            if (a == 4'd0) begin
                d[15:0]  = ($urandom % 4 != 0) ? (16'hFFF0 | 16'($urandom % 16)) : 16'($urandom);
                d[31:16] = good ? 16'h5A5A : 16'($urandom);
            end else begin
                d[7:0]  = {($urandom % 8 != 0), 2'($urandom), 1'($urandom), 1'($urandom),
                           ($urandom % 3 == 0) ? 3'($urandom) : 3'($urandom % 2)};
                d[31:8] = good ? 24'hA5A5A5 : 24'($urandom);
            end
            cyc(($urandom % 5) == 0, a, d);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule